// File: doc/BRIEF.md
# Scheduled Battery Health Check Latch

This block decides when the backup battery of a battery-backed memory is measured and holds the verdict between measurements. A check starts each time the main supply comes into tolerance (a power-up) and again after every long interval for as long as the supply stays good. Each check opens a measurement window so an external comparator can settle. On the last cycle of that window, one strobe cycle samples the comparator result and latches it.

The latched verdict drives an open-drain style enable. A 1 means the driver pulls the shared battery-low line to ground. A 0 means the line is released to its pull-up. The verdict does not follow the comparator between checks. It changes only when a later scheduled check finds a different result. A second output records whether the latest low verdict came from a power-up check or from a periodic check. A low verdict at power-up means the stored data may already be lost. A low verdict at a periodic check means the battery is close to end of life while the data is still intact.

While the supply is out of tolerance, nothing is measured. Any check in progress is dropped, and both outputs keep their values. The interval and the settling window are parameters, so a simulation can use short values while silicon uses an interval of at least 24 hours.

Top module: `battery_check_sched`

## Requirements
- R1: When `supply_ok` is sampled high at a clock edge while the block is idle in backup, a power-up check starts. `meas_en` is 1 for the next SETTLE_CYC cycles, and the comparator is sampled at the SETTLE_CYC-th edge after the starting edge.
- R2: While `supply_ok` stays high, further checks follow the same window shape and repeat every INTERVAL_CYC+SETTLE_CYC cycles.
- R3: At the clock edge that ends a strobe cycle, `bl_pull_low` takes the value of `cmp_below`. `cmp_below` is 1 when the battery is below threshold, and `bl_pull_low` is 1 when the line is pulled low.
- R4: Between strobes, `bl_pull_low` and `low_src_periodic` hold their values, whatever `cmp_below` does.
- R5: While `supply_ok` is low, `meas_en` and `sample_strobe` are 0 and both latched outputs hold. A check cut short by a dropout is abandoned, and the next rise of `supply_ok` starts a new power-up check from the beginning.
- R6: `sample_strobe` is high for exactly one cycle, the last cycle of a `meas_en` window.
- R7: `low_src_periodic` is 1 when the latched low verdict came from a periodic check. It is 0 when that verdict came from a power-up check, and 0 whenever `bl_pull_low` is 0.
- R8: During and right after reset, `bl_pull_low`, `low_src_periodic`, `meas_en` and `sample_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Main supply in tolerance |
| cmp_below | input | 1 | Comparator result: 1 means the battery is below threshold |
| meas_en | output | 1 | Measurement window open (enables the comparator) |
| sample_strobe | output | 1 | Cycle in which the comparator is sampled |
| bl_pull_low | output | 1 | Open-drain enable: 1 pulls the battery-low line low |
| low_src_periodic | output | 1 | 1 when the low verdict came from a periodic check |

## Verification
The bench uses a short configuration: a three-cycle window and a five-cycle interval. It models the schedule arithmetically as the cycle count since the supply came up, taken modulo the check period. Four kinds of stimulus are used:
- A steady comparator low, then high, to show the power-up and periodic verdicts and the clearing of the verdict.
- A comparator that toggles with a cycle-level pattern, which shows the sample is taken only on the strobe cycle and not at other times.
- A sweep of supply dropouts at every offset within two check periods, which shows abandoned checks, held verdicts and restarted power-up checks.
- Short supply pulses that never reach the strobe.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        ST_BACKUP = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WAIT   = 2'd2
    } sched_st_e;

    typedef enum logic {
        SRC_POWERUP  = 1'b0,
        SRC_PERIODIC = 1'b1
    } chk_src_e;

    typedef struct packed {
        sched_st_e st;
        chk_src_e  src;
    } sched_regs_t;

    typedef struct packed {
        logic low;
        logic periodic;
    } verdict_t;

endpackage

// File: rtl/bcs_span_counter.sv
module bcs_span_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         at_limit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (cnt_q != limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_limit = (cnt_q == limit);
endmodule

// File: rtl/bcs_verdict_latch.sv
module bcs_verdict_latch
    import bcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic below,
    input  logic from_periodic,
    output logic low_o,
    output logic periodic_o
);
    verdict_t v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (strobe) begin
            v_d.low      = below;
            v_d.periodic = below & from_periodic;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign low_o      = v_q.low;
    assign periodic_o = v_q.periodic;
endmodule

// File: rtl/battery_check_sched.sv
module battery_check_sched
    import bcs_pkg::*;
#(
    parameter longint unsigned INTERVAL_CYC = 64'd4_320_000_000_000,
    parameter int unsigned     SETTLE_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic cmp_below,
    output logic meas_en,
    output logic sample_strobe,
    output logic bl_pull_low,
    output logic low_src_periodic
);
    localparam longint unsigned SETTLE_L = longint'(SETTLE_CYC);
    localparam longint unsigned SPAN_MAX = (INTERVAL_CYC > SETTLE_L) ? INTERVAL_CYC : SETTLE_L;
    localparam int unsigned     CNT_W    = (SPAN_MAX < 2) ? 1 : $clog2(SPAN_MAX);
    localparam logic [CNT_W-1:0] IVL_LAST = CNT_W'(INTERVAL_CYC - 1);
    localparam logic [CNT_W-1:0] STL_LAST = CNT_W'(SETTLE_L - 1);

    sched_regs_t r_d, r_q;
    logic             span_clear;
    logic             span_done;
    logic [CNT_W-1:0] span_limit;
    logic             strobe;

    assign span_limit = (r_q.st == ST_WAIT) ? IVL_LAST : STL_LAST;

    always_comb begin
        r_d        = r_q;
        span_clear = 1'b0;
        strobe     = 1'b0;
        if (!supply_ok) begin
            r_d.st     = ST_BACKUP;
            span_clear = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_BACKUP: begin
                    r_d.st     = ST_SETTLE;
                    r_d.src    = SRC_POWERUP;
                    span_clear = 1'b1;
                end
                ST_SETTLE: begin
                    if (span_done) begin
                        strobe     = 1'b1;
                        r_d.st     = ST_WAIT;
                        span_clear = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (span_done) begin
                        r_d.st     = ST_SETTLE;
                        r_d.src    = SRC_PERIODIC;
                        span_clear = 1'b1;
                    end
                end
                default: begin
                    r_d.st     = ST_BACKUP;
                    span_clear = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_BACKUP, src: SRC_POWERUP};
        end else begin
            r_q <= r_d;
        end
    end

    bcs_span_counter #(.W(CNT_W)) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (span_clear),
        .limit    (span_limit),
        .at_limit (span_done)
    );

    bcs_verdict_latch u_verdict (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe        (strobe),
        .below         (cmp_below),
        .from_periodic (r_q.src == SRC_PERIODIC),
        .low_o         (bl_pull_low),
        .periodic_o    (low_src_periodic)
    );

    assign meas_en       = supply_ok && (r_q.st == ST_SETTLE);
    assign sample_strobe = strobe;
endmodule

// File: rtl/battery_check_sched_chk.sv
module battery_check_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic cmp_below,
    input logic meas_en,
    input logic sample_strobe,
    input logic bl_pull_low,
    input logic low_src_periodic
);
    p_powerup_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |=> (meas_en || !supply_ok));

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> (bl_pull_low == $past(cmp_below)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |=> ($stable(bl_pull_low) && $stable(low_src_periodic)));

    p_backup_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> $stable(bl_pull_low));

    p_strobe_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> meas_en);

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    p_src_implies_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        low_src_periodic |-> bl_pull_low);

    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r8: assert (!bl_pull_low && !low_src_periodic);
        end
    end
endmodule

bind battery_check_sched battery_check_sched_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .supply_ok        (supply_ok),
    .cmp_below        (cmp_below),
    .meas_en          (meas_en),
    .sample_strobe    (sample_strobe),
    .bl_pull_low      (bl_pull_low),
    .low_src_periodic (low_src_periodic)
);

// File: tb/battery_check_sched_bench.sv
`timescale 1ns/1ps
module battery_check_sched_bench;
    localparam int S = 3;
    localparam int I = 5;
    localparam int P = S + I;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic cmp_below = 1'b0;
    logic meas_en, sample_strobe, bl_pull_low, low_src_periodic;

    int n_run = 0;
    int n_fail = 0;
    int t = 0;
    logic exp_low = 1'b0;
    logic exp_per = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    battery_check_sched #(.INTERVAL_CYC(I), .SETTLE_CYC(S)) u_battery_check_sched (
        .clk              (clk),
        .rst_n            (rst_n),
        .supply_ok        (supply_ok),
        .cmp_below        (cmp_below),
        .meas_en          (meas_en),
        .sample_strobe    (sample_strobe),
        .bl_pull_low      (bl_pull_low),
        .low_src_periodic (low_src_periodic)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (t=%0d, time %0t)", req, act, exp, t, $time);
        end
    endtask

    task automatic step(input logic sup, input logic cmp);
        logic em, es;
        string rq;
        @(negedge clk);
        supply_ok = sup;
        cmp_below = cmp;
        #2;
        em = sup && (t >= 1) && (((t - 1) % P) < S);
        es = sup && (t >= 1) && (((t - 1) % P) == S - 1);
        rq = !sup ? "R5" : ((t > P) ? "R2" : "R1");
        check(rq, meas_en, em);
        check("R6", sample_strobe, es);
        @(posedge clk);
        if (es) begin
            exp_low = cmp;
            exp_per = cmp && (t > P);
        end
        t = sup ? t + 1 : 0;
        #1;
        check(es ? "R3" : (sup ? "R4" : "R5"), bl_pull_low, exp_low);
        check("R7", low_src_periodic, exp_per);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8", bl_pull_low, 1'b0);
        check("R8", low_src_periodic, 1'b0);
        check("R8", meas_en, 1'b0);
        check("R8", sample_strobe, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // low at power-up, then stays low into periodic checks, then recovers
        for (int i = 0; i < 3 * P; i++) step(1'b1, (i < P + 2) ? 1'b1 : 1'b0);
        // low found by a periodic check only
        for (int i = 0; i < 2 * P; i++) step(1'b1, 1'b1);
        // comparator toggling off-strobe
        for (int i = 0; i < 6 * P; i++) step(1'b1, ((i % 3) == 0) ? 1'b1 : 1'b0);
        // dropout sweep at every offset across two periods
        for (int o = 0; o <= 2 * P + 1; o++) begin
            step(1'b0, 1'b1);
            step(1'b0, 1'b0);
            for (int i = 0; i < o; i++) step(1'b1, ((i + o) % 2) == 1);
        end
        // short supply pulses that never reach the strobe
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
        end
        for (int i = 0; i < 2 * P; i++) step(1'b1, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule